// File: doc/BRIEF.md
# Paged Write Buffer with Address Counter

This block is the storage core behind a byte-serial memory front end. The front end decodes bus conditions into byte-level events: a start marker, an address load, a data byte to write, a request for a read byte, and a stop marker. The block feeds these events into a word-address counter, a one-page collect buffer and a register-array memory. Each event kind moves the address differently. Write bytes advance only the in-page bits of the address, so a long burst wraps round and overwrites its own earlier bytes. Read requests advance the full address and wrap from the last byte of the array to byte 0.

Written bytes are held in the buffer and reach the array only after a stop. If write protect is low at that stop and at least one byte is buffered, a busy period of `WR_CYCLES` clock cycles starts. The buffered bytes land in the array on the last cycle of that period, and only the positions that were actually written change. A start event before the stop throws the buffer away. This is how the address-setting dummy write of a random read leaves the array untouched. The counter keeps its value between operations, so a read that follows uses the last address touched plus one.

Events enter on a valid/ready channel. `ev_ready` is low while the write cycle runs, which is when `busy` is high, and while a read byte is waiting at the output. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both high. Read bytes leave on a second valid/ready channel. Once `rd_valid` rises, it and `rd_data` stay fixed until a cycle with `rd_ready` high, so the consumer can stall the block for as long as it needs.

Top module: `pgw_store`

## Requirements
- R1: After reset `busy` and `rd_valid` are 0, `ev_ready` is 1, the address counter is 0 and every array byte reads as 0.
- R2: Each accepted write event stores `ev_data` at the current address's in-page position and then adds one to the low `PAGE_W` address bits only. The upper bits (the page row) never change, so no byte lands outside the page.
- R3: When more than 2^`PAGE_W` bytes are written in one sequence, the in-page index wraps to 0 and later bytes replace earlier ones at the same position.
- R4: A commit changes only the positions that received a byte. Every other byte in that page and in the array keeps its value.
- R5: A stop event with write protect low and a non-empty buffer sets `busy` for exactly `WR_CYCLES` cycles. During that time `ev_ready` is 0. The bytes are in the array once `busy` has fallen.
- R6: Write protect is sampled at the stop event. If it is 1, no byte changes, `busy` stays 0 and the buffer is emptied, so a later stop commits nothing.
- R7: The counter keeps its value between operations. After a commit it points one past the last byte written, wrapped within the page, and a read with no address load returns the byte there.
- R8: Each accepted read event returns the byte at the current address and then adds one to the full address. Address 2^`ADDR_W`-1 is followed by address 0.
- R9: A start event empties the buffer without committing. A stop that follows it causes no busy period and no array change.
- R10: `rd_valid` rises in the cycle after a read event is accepted. `rd_valid` and `rd_data` then hold until a cycle with `rd_ready` high. `ev_ready` is 0 while `rd_valid` is 1.
- R11: Event codes on `ev_kind` are 0 start, 1 address load (from `ev_addr`), 2 write byte (from `ev_data`), 3 read byte and 4 stop. Any other code is accepted and changes neither the address nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event can be accepted this cycle |
| ev_kind | input | 3 | Event code (see R11) |
| ev_addr | input | ADDR_W | Address for a load event |
| ev_data | input | 8 | Byte for a write event |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| wp | input | 1 | Write protect, 1 blocks the whole array |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench samples each result on a falling edge. The read byte and `rd_valid` are checked at the first falling edge after the rising edge that accepted the read event. `busy` is checked at the falling edge just after the stop is accepted. From that point the bench counts falling edges with `busy` high and expects exactly `WR_CYCLES` of them. Array contents are checked only by later read events, after `busy` has dropped. A shadow memory, address and page buffer in the bench, updated by the rules above, supply the expected values.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_LOAD  = 3'd1,
    EV_WRITE = 3'd2,
    EV_READ  = 3'd3,
    EV_STOP  = 3'd4
  } ev_kind_e;
endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              wr_step,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned ROW_W = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] col_q;
  assign row_q = addr[ADDR_W-1:PAGE_W];
  assign col_q = addr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load_en) begin
      addr <= load_val;
    end else if (wr_step) begin
      addr <= {row_q, PAGE_W'(col_q + 1'b1)};
    end else if (rd_step) begin
      addr <= ADDR_W'(addr + 1'b1);
    end
  end

  // R2: a write step keeps the page row
  assert_row_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_step && !load_en) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

  // R8: a read step advances the whole address, wrapping at the top
  assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !load_en && !wr_step) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [pgw_pkg::BYTE_W-1:0]            wr_data,
  input  logic                                  clear,
  output logic [(1<<PAGE_W)-1:0]                mask,
  output logic [(1<<PAGE_W)-1:0][pgw_pkg::BYTE_W-1:0] data,
  output logic [ADDR_W-PAGE_W-1:0]              row
);
  localparam int unsigned PAGE  = 1 << PAGE_W;

  logic [PAGE_W-1:0] idx;
  assign idx = wr_addr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      row  <= '0;
    end else if (clear) begin
      mask <= '0;
    end else if (wr_en) begin
      mask[idx] <= 1'b1;
      if (mask == '0) row <= wr_addr[ADDR_W-1:PAGE_W];
    end
  end

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data[g] <= '0;
        end else if (wr_en && !clear && (idx == PAGE_W'(g))) begin
          data[g] <= wr_data;
        end
      end
    end
  endgenerate

  // R9: clearing leaves nothing pending
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));
endmodule

// File: rtl/pgw_wr_timer.sv
module pgw_wr_timer #(
  parameter int unsigned WR_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WR_CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R5: the final count ends the busy period
  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         commit,
  input  logic [ADDR_W-PAGE_W-1:0]                     row,
  input  logic [(1<<PAGE_W)-1:0]                       mask,
  input  logic [(1<<PAGE_W)-1:0][pgw_pkg::BYTE_W-1:0]  data,
  input  logic [ADDR_W-1:0]                            rd_addr,
  output logic [pgw_pkg::BYTE_W-1:0]                   rd_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;

  logic [pgw_pkg::BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (mask[i]) mem[{row, PAGE_W'(i)}] <= data[i];
      end
    end
  end

  assign rd_q = mem[rd_addr];
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [2:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [7:0]        ev_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  input  logic              wp,
  output logic              busy
);
  import pgw_pkg::*;

  localparam int unsigned PAGE  = 1 << PAGE_W;
  localparam int unsigned ROW_W = ADDR_W - PAGE_W;

  ev_kind_e                  kind;
  logic                      fire, is_start, is_load, is_write, is_read, is_stop;
  logic [ADDR_W-1:0]         addr;
  logic [PAGE-1:0]           pend_mask;
  logic [PAGE-1:0][BYTE_W-1:0] pend_data;
  logic [ROW_W-1:0]          pend_row;
  logic                      buf_clear, go_commit, done;
  logic [BYTE_W-1:0]         rd_q;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = !busy && !rd_valid;
  assign fire     = ev_valid && ev_ready;
  assign is_start = fire && (kind == EV_START);
  assign is_load  = fire && (kind == EV_LOAD);
  assign is_write = fire && (kind == EV_WRITE);
  assign is_read  = fire && (kind == EV_READ);
  assign is_stop  = fire && (kind == EV_STOP);

  assign go_commit = is_stop && !wp && (pend_mask != '0);
  assign buf_clear = is_start || (is_stop && !go_commit) || done;

  pgw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_en(is_load), .load_val(ev_addr),
    .wr_step(is_write), .rd_step(is_read), .addr(addr)
  );

  pgw_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(is_write), .wr_addr(addr),
    .wr_data(ev_data), .clear(buf_clear), .mask(pend_mask),
    .data(pend_data), .row(pend_row)
  );

  pgw_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(go_commit), .busy(busy), .done(done)
  );

  pgw_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(done), .row(pend_row),
    .mask(pend_mask), .data(pend_data), .rd_addr(addr), .rd_q(rd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (is_read) begin
      rd_valid <= 1'b1;
      rd_data  <= rd_q;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  // R6: a busy period only follows a stop taken with protect low
  assert_protect_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));

  // R10: a stalled read byte holds still
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R5: the buffer stays intact for the whole busy period
  assert_pending_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(pend_mask));
endmodule

// File: tb/pgw_store_tb.sv
module pgw_store_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PAGE_W = 3;
  localparam int unsigned WR_CYC = 20;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned PAGE   = 1 << PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, rd_ready = 1'b0, wp = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic [7:0] ev_data = '0;
  logic ev_ready, rd_valid, busy;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  pgw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_data(ev_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wp(wp), .busy(busy)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] sm [DEPTH];
  logic [7:0] sb [PAGE];
  bit smask [PAGE];
  int sa = 0, srow = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit any_pend();
    for (int i = 0; i < PAGE; i++) if (smask[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic send(int k, int a, int d);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1;
    ev_kind = 3'(k);
    ev_addr = ADDR_W'(a);
    ev_data = 8'(d);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_start();
    send(0, 0, 0);
    for (int i = 0; i < PAGE; i++) smask[i] = 1'b0;
  endtask

  task automatic do_load(int a);
    send(1, a, 0);
    sa = a % DEPTH;
  endtask

  task automatic do_write(int d);
    int idx;
    send(2, 0, d);
    idx = sa % PAGE;
    if (!any_pend()) srow = sa / PAGE;
    sb[idx] = 8'(d);
    smask[idx] = 1'b1;
    sa = (sa / PAGE) * PAGE + ((sa + 1) % PAGE);
  endtask

  task automatic do_stop(bit wpv);
    bit pend;
    int n;
    pend = any_pend();
    wp = wpv;
    send(4, 0, 0);
    if (pend && !wpv) begin
      chk(busy == 1'b1, "R5 busy after stop", int'(busy), 1);
      chk(ev_ready == 1'b0, "R5 ready low in busy", int'(ev_ready), 0);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == WR_CYC, "R5 busy length", n, WR_CYC);
      for (int i = 0; i < PAGE; i++) if (smask[i]) sm[srow * PAGE + i] = sb[i];
    end else begin
      chk(busy == 1'b0, "R6 no busy", int'(busy), 0);
    end
    for (int i = 0; i < PAGE; i++) smask[i] = 1'b0;
    wp = 1'b0;
  endtask

  task automatic do_read(int hold, string req);
    logic [7:0] exp;
    send(3, 0, 0);
    exp = sm[sa];
    chk(rd_valid == 1'b1, "R10 rd_valid", int'(rd_valid), 1);
    chk(rd_data == exp, req, int'(rd_data), int'(exp));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rd_valid && rd_data == exp && !ev_ready, "R10 hold", int'(rd_data), int'(exp));
    end
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    sa = (sa + 1) % DEPTH;
  endtask

  task automatic seek(int a);
    do_start();
    do_load(a);
    do_start();
  endtask

  initial begin
    repeat (1000 * 150) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    for (int i = 0; i < DEPTH; i++) sm[i] = '0;
    for (int i = 0; i < PAGE; i++) smask[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(ev_ready == 1'b1, "R1 ev_ready", int'(ev_ready), 1);
    do_read(0, "R1 zero at addr 0");

    // R4 partial page write, R7 counter after commit
    do_start(); do_load('h13); do_write('hA1); do_write('hA2); do_stop(1'b0);
    do_start(); do_read(0, "R7 current address after commit");
    seek('h10);
    for (int i = 0; i < PAGE; i++) do_read(0, "R4 partial page");

    // R3 page wrap overwrite, R2 row kept
    do_start(); do_load('h2E);
    for (int i = 0; i < 10; i++) do_write('hC0 + i);
    do_stop(1'b0);
    seek('h28);
    for (int i = 0; i < PAGE + 2; i++) do_read(0, "R3 wrap or R2 row");

    // R6 protected stop, then a plain stop commits nothing
    do_start(); do_load('h40); do_write('h11); do_write('h22); do_stop(1'b1);
    do_stop(1'b0);
    seek('h40); do_read(0, "R6 unchanged"); do_read(0, "R6 unchanged");

    // R9 start discards
    do_start(); do_load('h50); do_write('h55); do_start(); do_stop(1'b0);
    seek('h50); do_read(0, "R9 discarded");

    // R8 full-array wrap
    seek(DEPTH - 1); do_read(1, "R8 last byte"); do_read(0, "R8 wrap to 0");

    // R11 unknown code, R10 stalls
    send(7, 'h99, 'h77);
    do_read(3, "R11 unknown code no effect");

    for (int it = 0; it < 40; it++) begin
      int n;
      do_start(); do_load(int'($urandom % DEPTH));
      n = 1 + int'($urandom % 20);
      for (int j = 0; j < n; j++) do_write(int'($urandom % 256));
      do_stop(($urandom % 4) == 0);
      seek(int'($urandom % DEPTH));
      n = 1 + int'($urandom % 10);
      for (int j = 0; j < n; j++) do_read(int'($urandom % 3), "R8 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule